// File: doc/BRIEF.md
# Multi-Window PCI-to-VME Address Translator

This block sits behind a PCI target interface and decides, for each incoming transaction, whether it belongs to one of several programmable slave windows. Every window holds a lower limit, an exclusive upper limit, a translation offset and a packed control word. When a request falls inside an enabled window whose PCI space type matches, the block reports a hit, the index of the window, the VME address (the PCI address plus the window offset, wrapping at 32 bits) and the VME attributes taken from that window's control word.

Software programs the windows and a small command register through a 32-bit register port at fixed offsets. The command register's I/O and memory enables gate the decoding of I/O-space windows and memory-space windows respectively. The lookup is combinational and is registered once, so every answer appears one clock after its request. Window 0 resolves addresses to 4 KB and the other windows to 64 KB.

Top module: `pci_vme_xlate`

## Requirements
- R1: After reset the outputs are zero, every register reads zero and no request hits.
- R2: Window i occupies four words starting at 0x100 + 0x14*i, in the order control, lower limit, upper limit, offset. The command register is at 0x004 and keeps bits 2:0 (bit 0 I/O enable, bit 1 memory enable, bit 2 bus master enable). Reads are combinational and unmapped offsets read zero.
- R3: A window matches an address A only when lower <= A < upper on the significant bits.
- R4: The VME address is the PCI address plus the window offset, modulo 2^32.
- R5: The attributes come from the winning control word: bits 23:22 data width (01 D16, 10 D32, 11 D64), bits 18:16 address space (001 A24, 010 A32), bits 15:14 program/data (00 data), bit 12 supervisor, bit 30 posted write, bit 8 block transfer.
- R6: Control bits 1:0 select the PCI space, 01 for I/O and 00 for memory; a window never answers a request of the other space.
- R7: An I/O window decodes only while command bit 0 is set and a memory window only while command bit 1 is set.
- R8: A window whose enable (control bit 31) is clear, or whose upper limit is not above its lower limit, never hits.
- R9: When several windows match, the lowest-numbered one wins.
- R10: The result valid flag follows the request valid flag by exactly one clock, and a hit is reported only in a result-valid cycle.
- R11: Window 0 compares and translates on address bits 31:12, the others on bits 31:16; limit and offset bits below that read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 32 | PCI address to decode |
| req_io | input | 1 | 1 for I/O space, 0 for memory space |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | A window matched |
| res_win | output | 2 | Index of the matching window |
| vme_addr | output | 32 | Translated VME address |
| vme_aspace | output | 3 | VME address space code |
| vme_dwidth | output | 2 | VME data width code |
| vme_pgm | output | 2 | Program/data code |
| vme_priv | output | 1 | Supervisor access |
| vme_posted | output | 1 | Posted write allowed |
| vme_blt | output | 1 | Block transfer allowed |

## Verification
Register writes take effect on the clock edge that samples the strobe, and read data is combinational, so the bench reads back half a cycle after the write edge. Lookup results pass through one register: the bench holds a request across one rising edge and samples all result outputs one nanosecond after that edge, then checks that the result valid flag drops one edge after the request is withdrawn. Back-to-back requests are checked edge by edge, so each answer is matched to the request of the cycle before.

// File: rtl/pvx_pkg.sv
package pvx_pkg;

   localparam int CB_EN    = 31;
   localparam int CB_PW    = 30;
   localparam int CB_DW_HI = 23;
   localparam int CB_DW_LO = 22;
   localparam int CB_AS_HI = 18;
   localparam int CB_AS_LO = 16;
   localparam int CB_PG_HI = 15;
   localparam int CB_PG_LO = 14;
   localparam int CB_SUP   = 12;
   localparam int CB_BLT   = 8;

   localparam logic [1:0] SPACE_MEM = 2'b00;
   localparam logic [1:0] SPACE_IO  = 2'b01;

   typedef struct packed {
      logic [2:0] aspace;
      logic [1:0] dwidth;
      logic [1:0] pgm;
      logic       priv;
      logic       posted;
      logic       blt;
   } vme_attr_t;

   function automatic vme_attr_t attr_of(input logic [31:0] c);
      vme_attr_t a;
      a.aspace = c[CB_AS_HI:CB_AS_LO];
      a.dwidth = c[CB_DW_HI:CB_DW_LO];
      a.pgm    = c[CB_PG_HI:CB_PG_LO];
      a.priv   = c[CB_SUP];
      a.posted = c[CB_PW];
      a.blt    = c[CB_BLT];
      return a;
   endfunction

endpackage

// File: rtl/pvx_window.sv
module pvx_window
   import pvx_pkg::*;
#(
   parameter int          GRAN     = 16,
   parameter logic [11:0] REG_BASE = 12'h100
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [11:0] wr_addr,
   input  logic [31:0] wr_data,
   input  logic [11:0] rd_addr,
   output logic [31:0] rd_data,
   input  logic [31:0] lk_addr,
   input  logic        lk_io,
   input  logic        io_en,
   input  logic        mem_en,
   output logic        match,
   output logic [31:0] vaddr,
   output vme_attr_t   attr
);
   localparam int HW = 32 - GRAN;
   localparam logic [11:0] A_CTRL  = REG_BASE;
   localparam logic [11:0] A_LOW   = REG_BASE + 12'h4;
   localparam logic [11:0] A_HIGH  = REG_BASE + 12'h8;
   localparam logic [11:0] A_OFFS  = REG_BASE + 12'hC;

   if (GRAN < 1 || GRAN > 31) begin : g_bad_gran
      $error("pvx_window: GRAN must lie in 1..31");
   end

   logic [31:0]   ctrl_q;
   logic [HW-1:0] low_q, high_q, offs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         low_q  <= '0;
         high_q <= '0;
         offs_q <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_CTRL:  ctrl_q <= wr_data;
            A_LOW:   low_q  <= wr_data[31:GRAN];
            A_HIGH:  high_q <= wr_data[31:GRAN];
            A_OFFS:  offs_q <= wr_data[31:GRAN];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (rd_addr)
         A_CTRL:  rd_data = ctrl_q;
         A_LOW:   rd_data = {low_q,  {GRAN{1'b0}}};
         A_HIGH:  rd_data = {high_q, {GRAN{1'b0}}};
         A_OFFS:  rd_data = {offs_q, {GRAN{1'b0}}};
         default: rd_data = '0;
      endcase
   end

   logic [HW-1:0] a_hi;
   logic          space_ok, range_ok;

   assign a_hi     = lk_addr[31:GRAN];
   assign space_ok = lk_io ? (ctrl_q[1:0] == SPACE_IO  && io_en)
                           : (ctrl_q[1:0] == SPACE_MEM && mem_en);
   assign range_ok = (high_q > low_q) && (a_hi >= low_q) && (a_hi < high_q);
   assign match    = ctrl_q[CB_EN] && space_ok && range_ok;
   assign vaddr    = {a_hi + offs_q, lk_addr[GRAN-1:0]};
   assign attr     = attr_of(ctrl_q);

   a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[CB_EN] == 1'b0) |-> !match);
   a_r6_space_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (match && lk_io) |-> (ctrl_q[1:0] == SPACE_IO));

endmodule

// File: rtl/pvx_pick.sv
module pvx_pick #(
   parameter int N  = 3,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      gnt = '0;
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            gnt    = '0;
            gnt[i] = 1'b1;
            idx    = IW'(i);
            any    = 1'b1;
         end
      end
   end

   always_comb begin
      a_r9_single_winner: assert ($onehot0(gnt));
   end

endmodule

// File: rtl/pci_vme_xlate.sv
module pci_vme_xlate
   import pvx_pkg::*;
#(
   parameter int NUM_WIN     = 3,
   parameter int FINE_GRAN   = 12,
   parameter int COARSE_GRAN = 16,
   parameter int WIN_IW      = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [11:0] reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        req_valid,
   input  logic [31:0] req_addr,
   input  logic        req_io,
   output logic        res_valid,
   output logic        res_hit,
   output logic [WIN_IW-1:0] res_win,
   output logic [31:0] vme_addr,
   output logic [2:0]  vme_aspace,
   output logic [1:0]  vme_dwidth,
   output logic [1:0]  vme_pgm,
   output logic        vme_priv,
   output logic        vme_posted,
   output logic        vme_blt
);
   localparam logic [11:0] CMD_ADDR  = 12'h004;
   localparam int          WIN_STRIDE = 'h14;
   localparam int          MAP_END   = 'h100 + WIN_STRIDE * NUM_WIN;

   if (NUM_WIN < 1 || MAP_END > 'hFFF) begin : g_bad_count
      $error("pci_vme_xlate: NUM_WIN does not fit the register map");
   end
   if ((1 << WIN_IW) < NUM_WIN) begin : g_bad_iw
      $error("pci_vme_xlate: WIN_IW too narrow for NUM_WIN");
   end

   logic [2:0] cmd_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             cmd_q <= '0;
      else if (reg_wr && reg_addr == CMD_ADDR) cmd_q <= reg_wdata[2:0];
   end

   logic [31:0]  w_rdata [NUM_WIN];
   logic [31:0]  w_vaddr [NUM_WIN];
   vme_attr_t    w_attr  [NUM_WIN];
   logic [NUM_WIN-1:0] w_match;

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      localparam int GR = (i == 0) ? FINE_GRAN : COARSE_GRAN;
      pvx_window #(
         .GRAN     (GR),
         .REG_BASE (12'(12'h100 + WIN_STRIDE * i))
      ) u_win (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (reg_wr),
         .wr_addr (reg_addr),
         .wr_data (reg_wdata),
         .rd_addr (reg_addr),
         .rd_data (w_rdata[i]),
         .lk_addr (req_addr),
         .lk_io   (req_io),
         .io_en   (cmd_q[0]),
         .mem_en  (cmd_q[1]),
         .match   (w_match[i]),
         .vaddr   (w_vaddr[i]),
         .attr    (w_attr[i])
      );
   end

   always_comb begin
      reg_rdata = (reg_addr == CMD_ADDR) ? {29'd0, cmd_q} : 32'd0;
      for (int i = 0; i < NUM_WIN; i++) reg_rdata = reg_rdata | w_rdata[i];
   end

   logic [NUM_WIN-1:0] gnt;
   logic [WIN_IW-1:0]  win_idx;
   logic               any_hit;

   pvx_pick #(.N(NUM_WIN), .IW(WIN_IW)) u_pick (
      .req (w_match),
      .gnt (gnt),
      .idx (win_idx),
      .any (any_hit)
   );

   logic [31:0] sel_vaddr;
   vme_attr_t   sel_attr;
   always_comb begin
      sel_vaddr = '0;
      sel_attr  = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (gnt[i]) begin
            sel_vaddr = sel_vaddr | w_vaddr[i];
            sel_attr  = sel_attr  | w_attr[i];
         end
      end
   end

   logic hit_now;
   assign hit_now = req_valid && any_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_hit    <= 1'b0;
         res_win    <= '0;
         vme_addr   <= '0;
         vme_aspace <= '0;
         vme_dwidth <= '0;
         vme_pgm    <= '0;
         vme_priv   <= 1'b0;
         vme_posted <= 1'b0;
         vme_blt    <= 1'b0;
      end else begin
         res_valid  <= req_valid;
         res_hit    <= hit_now;
         res_win    <= hit_now ? win_idx : '0;
         vme_addr   <= hit_now ? sel_vaddr : '0;
         vme_aspace <= hit_now ? sel_attr.aspace : '0;
         vme_dwidth <= hit_now ? sel_attr.dwidth : '0;
         vme_pgm    <= hit_now ? sel_attr.pgm : '0;
         vme_priv   <= hit_now && sel_attr.priv;
         vme_posted <= hit_now && sel_attr.posted;
         vme_blt    <= hit_now && sel_attr.blt;
      end
   end

   a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);
   a_r10_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid);
   a_r10_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> res_valid);
   a_r7_mem_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_io && !cmd_q[1]) |=> !res_hit);
   a_r7_io_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_io && !cmd_q[0]) |=> !res_hit);

endmodule

// File: tb/pci_vme_xlate_test.sv
`timescale 1ns/1ps
module pci_vme_xlate_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_io = 1'b0;
   logic        res_valid, res_hit;
   logic [1:0]  res_win;
   logic [31:0] vme_addr;
   logic [2:0]  vme_aspace;
   logic [1:0]  vme_dwidth, vme_pgm;
   logic        vme_priv, vme_posted, vme_blt;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   pci_vme_xlate uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
      .req_addr(req_addr), .req_io(req_io), .res_valid(res_valid),
      .res_hit(res_hit), .res_win(res_win), .vme_addr(vme_addr),
      .vme_aspace(vme_aspace), .vme_dwidth(vme_dwidth), .vme_pgm(vme_pgm),
      .vme_priv(vme_priv), .vme_posted(vme_posted), .vme_blt(vme_blt)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic wreg(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1 chk(tag, reg_rdata, exp);
   endtask

   // one request held across one rising edge; results sampled 1 ns after it
   task automatic look(input logic [31:0] a, input logic io);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_io = io;
      @(posedge clk);
      #1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic look_hold(input logic [31:0] a, input logic io);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_io = io;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset;
      chk("R1 res_valid", {31'd0, res_valid}, 0);
      chk("R1 res_hit", {31'd0, res_hit}, 0);
      chk("R1 vme_addr", vme_addr, 0);
      rchk("R1 ctrl2 read", 12'h128, 0);
      rchk("R1 cmd read", 12'h004, 0);
      look_hold(32'h4000_0000, 1'b0);
      chk("R1 no hit", {31'd0, res_hit}, 0);
      chk("R10 valid", {31'd0, res_valid}, 1);
      @(negedge clk); req_valid = 1'b0;
   endtask

   task automatic t_regmap;
      wreg(12'h104, 32'h0000_1ABC);
      rchk("R11 win0 low 4KB", 12'h104, 32'h0000_1000);
      wreg(12'h12C, 32'h4000_8123);
      rchk("R11 win2 low 64KB", 12'h12C, 32'h4000_0000);
      wreg(12'h004, 32'hFFFF_FFFF);
      rchk("R2 cmd bits", 12'h004, 32'h0000_0007);
      wreg(12'h004, 32'h0);
      wreg(12'h128, 32'hC0C2_0100);
      rchk("R2 ctrl2", 12'h128, 32'hC0C2_0100);
      rchk("R2 unmapped", 12'h0FC, 32'h0);
      wreg(12'h130, 32'h6000_0000);
      wreg(12'h134, 32'hC000_0000);
      rchk("R2 win2 offset", 12'h134, 32'hC000_0000);
   endtask

   task automatic t_win2;
      look_hold(32'h4000_0000, 1'b0);
      chk("R7 mem disabled", {31'd0, res_hit}, 0);
      @(negedge clk); req_valid = 1'b0;
      wreg(12'h004, 32'h2);
      look_hold(32'h4000_0000, 1'b0);
      chk("R3 low edge hit", {31'd0, res_hit}, 1);
      chk("R3 win idx", {30'd0, res_win}, 2);
      chk("R4 wrap translate", vme_addr, 32'h0);
      chk("R5 aspace A32", {29'd0, vme_aspace}, 2);
      chk("R5 dwidth D64", {30'd0, vme_dwidth}, 3);
      chk("R5 pgm data", {30'd0, vme_pgm}, 0);
      chk("R5 nonpriv", {31'd0, vme_priv}, 0);
      chk("R5 posted", {31'd0, vme_posted}, 1);
      chk("R5 blt", {31'd0, vme_blt}, 1);
      @(negedge clk); req_valid = 1'b0;
      look(32'h5FFF_FFFF, 1'b0);
      chk("R3 top hit", {31'd0, res_hit}, 1);
      chk("R4 top translate", vme_addr, 32'h1FFF_FFFF);
      look(32'h6000_0000, 1'b0);
      chk("R3 upper excluded", {31'd0, res_hit}, 0);
      look(32'h3FFF_FFFF, 1'b0);
      chk("R3 below low", {31'd0, res_hit}, 0);
      wreg(12'h004, 32'h3);
      look(32'h4000_0000, 1'b1);
      chk("R6 io on mem window", {31'd0, res_hit}, 0);
   endtask

   task automatic t_win0;
      wreg(12'h104, 32'h0);
      wreg(12'h108, 32'h0000_1000);
      wreg(12'h10C, 32'h0000_1000);
      wreg(12'h100, 32'h8041_1001);
      wreg(12'h004, 32'h2);
      look(32'h0000_0ABC, 1'b1);
      chk("R7 io disabled", {31'd0, res_hit}, 0);
      wreg(12'h004, 32'h3);
      look(32'h0000_0ABC, 1'b1);
      chk("R6 io hit", {31'd0, res_hit}, 1);
      chk("R9 win0", {30'd0, res_win}, 0);
      chk("R11 4KB translate", vme_addr, 32'h0000_1ABC);
      chk("R5 aspace A24", {29'd0, vme_aspace}, 1);
      chk("R5 dwidth D16", {30'd0, vme_dwidth}, 1);
      chk("R5 supervisor", {31'd0, vme_priv}, 1);
      chk("R5 no posted", {31'd0, vme_posted}, 0);
      chk("R5 no blt", {31'd0, vme_blt}, 0);
      look(32'h0000_1000, 1'b1);
      chk("R11 4KB bound", {31'd0, res_hit}, 0);
      look(32'h0000_0ABC, 1'b0);
      chk("R6 mem on io window", {31'd0, res_hit}, 0);
   endtask

   task automatic t_prio;
      wreg(12'h118, 32'h1000_0000);
      wreg(12'h11C, 32'h5000_0000);
      wreg(12'h120, 32'h1000_0000);
      wreg(12'h114, 32'hC082_0100);
      look(32'h4800_0000, 1'b0);
      chk("R9 overlap lowest", {30'd0, res_win}, 1);
      chk("R9 overlap addr", vme_addr, 32'h5800_0000);
      chk("R5 dwidth D32", {30'd0, vme_dwidth}, 2);
      look(32'h5000_0000, 1'b0);
      chk("R9 only win2", {30'd0, res_win}, 2);
      chk("R4 win2 addr", vme_addr, 32'h1000_0000);
   endtask

   task automatic t_never;
      wreg(12'h11C, 32'h1000_0000);
      look(32'h1000_0000, 1'b0);
      chk("R8 empty range", {31'd0, res_hit}, 0);
      wreg(12'h128, 32'h40C2_0100);
      look(32'h4000_0000, 1'b0);
      chk("R8 disabled", {31'd0, res_hit}, 0);
   endtask

   task automatic t_latency;
      look_hold(32'h0000_0ABC, 1'b1);
      chk("R10 first hit", {31'd0, res_hit}, 1);
      @(negedge clk); req_addr = 32'h0000_1000;
      @(posedge clk); #1;
      chk("R10 second miss", {31'd0, res_hit}, 0);
      chk("R10 second valid", {31'd0, res_valid}, 1);
      @(negedge clk); req_valid = 1'b0;
      @(posedge clk); #1;
      chk("R10 valid drops", {31'd0, res_valid}, 0);
      chk("R10 hit drops", {31'd0, res_hit}, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 t_reset_pre();
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_win2();
      t_win0();
      t_prio();
      t_never();
      t_latency();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   task automatic t_reset_pre;
      chk("R1 in reset valid", {31'd0, res_valid}, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule